// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Protocol Engine

This block is the byte-level controller of a two-wire serial EEPROM slave. A bus front end hands it single-cycle strobes: a start strobe, a stop strobe, an SCL rising strobe carrying the sampled data line, and an SCL falling strobe. The engine answers through one pull-low enable for the data line. It checks the slave address byte against the device identifier and the strap pins, keeps the word address pointer, and sends acknowledges. It handles byte and page writes and current-address, random and sequential reads.

Read data comes through a combinational read port indexed by the pointer. Write data goes to a page buffer port one byte at a time, and a one-cycle request starts the nonvolatile write cycle when the master sends stop. The `BYTES` parameter sets the capacity, from 128 to 2048. It also decides how many address-byte bits compare with the straps and how many become upper word-address bits. A write-protect input refuses data bytes. A busy input, raised during the nonvolatile cycle, makes the engine ignore the bus completely so the master can poll for an acknowledge.

Top module: `i2c_eeprom_engine`

## Requirements
- R1: Bytes move MSB first. The receiving side pulls the data line low during the ninth clock to acknowledge. `sda_pull` changes only in the cycle after an SCL falling strobe, a start strobe or a stop strobe.
- R2: The slave address byte matches when bits 7..4 are 1010 and the strap compare passes. Bit 0 is the direction: 1 means read, 0 means write. With W = log2(BYTES), the low max(0, W-8) bits of bits 3..1 become word-address bits above bit 7, and the remaining upper bits of 3..1 must equal the same-position strap bits. At 512 bytes, bits 3..2 compare with `strap[2:1]`, bit 1 is word-address bit 8, and `strap[0]` is ignored.
- R3: After an address byte that does not match, the engine sends no acknowledge and keeps the data line released until the next start or stop.
- R4: In a write, the byte after the address is acknowledged and loads the pointer as {block bits, byte}. Each data byte is acknowledged and placed on the page buffer port at the pointer. A stop after at least one accepted data byte gives a one-cycle `wr_go`.
- R5: During a write, the pointer advances inside its 16-byte page. Only the low four bits count up, and they wrap, so a 17th byte overwrites the first location of the page.
- R6: If a start arrives while `wr_busy` is high, the engine acknowledges nothing until the next start, including its own address. Once busy has dropped, the same address is acknowledged.
- R7: A random read is a write header with a word address, then a repeated start and a read header. It returns the byte at the newly loaded address.
- R8: A read header with no word address before it returns the byte at the last accessed address plus one. The block bits of a read header do not change the pointer.
- R9: Each read byte that the master acknowledges is followed by the next address. The read pointer counts across the whole array and wraps from BYTES-1 to 0.
- R10: If the master does not acknowledge a read byte, the engine releases the data line and drives nothing more until the next start or stop.
- R11: While `wr_protect` is high, the address and word-address bytes are acknowledged, but the data byte gets no acknowledge and produces no page buffer write. The stop that follows gives no `wr_go`.
- R12: A start at any point, even in the middle of a byte, drops the current transfer, cancels any pending write request, and begins address reception again. A stop returns the engine to idle with the line released.
- R13: During reset, `sda_pull`, `pg_we` and `wr_go` are low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Start condition strobe (one cycle) |
| bus_stop | input | 1 | Stop condition strobe (one cycle) |
| scl_rise | input | 1 | SCL rising strobe; `sda_in` is sampled with it |
| scl_fall | input | 1 | SCL falling strobe |
| sda_in | input | 1 | Resolved data line level |
| sda_pull | output | 1 | 1 pulls the data line low |
| strap | input | 3 | Device address straps, bit 2 highest |
| wr_protect | input | 1 | 1 refuses data bytes of writes |
| wr_busy | input | 1 | Nonvolatile write cycle in progress |
| rd_addr | output | log2(BYTES) | Read port address (the word pointer) |
| rd_data | input | 8 | Byte at `rd_addr`, same cycle |
| pg_we | output | 1 | Page buffer write strobe |
| pg_addr | output | log2(BYTES) | Page buffer write address |
| pg_data | output | 8 | Page buffer write data |
| wr_go | output | 1 | Request to start the write cycle |

## Verification
The assertions assume a front end that follows the bus rules. Every falling strobe comes after a rising strobe for the same bit. Start and stop never share a cycle with an SCL strobe. `wr_busy` rises only while the engine is idle after the stop that raised `wr_go`. `wr_protect` changes only between transfers. The bench master keeps to this by building each bit from separate rise and fall cycles, keeping start and stop in cycles of their own, and toggling protect only while the bus is idle. Its memory model starts a fixed busy count one cycle after `wr_go`.

// File: rtl/i2c_eeprom_engine.sv
module i2c_eeprom_engine #(
  parameter int BYTES = 2048,
  parameter int PAGE  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_start,
  input  logic                      bus_stop,
  input  logic                      scl_rise,
  input  logic                      scl_fall,
  input  logic                      sda_in,
  output logic                      sda_pull,
  input  logic [2:0]                strap,
  input  logic                      wr_protect,
  input  logic                      wr_busy,
  output logic [$clog2(BYTES)-1:0]  rd_addr,
  input  logic [7:0]                rd_data,
  output logic                      pg_we,
  output logic [$clog2(BYTES)-1:0]  pg_addr,
  output logic [7:0]                pg_data,
  output logic                      wr_go
);

  localparam int AW   = $clog2(BYTES);
  localparam int PW   = $clog2(PAGE);
  localparam int NSEL = (AW > 8) ? AW - 8 : 0;
  localparam logic [2:0] CMASK = 3'(7 << NSEL);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WAD, S_WDT, S_RD, S_WAIT} st_t;

  st_t          st;
  logic [3:0]   cnt;
  logic [7:0]   sr, tx;
  logic [2:0]   dbits;
  logic         rwb, ack, mack, pend;
  logic [AW-1:0] ptr, ptr_pg;

  wire dev_hit = (sr[7:4] == 4'hA) && (((sr[3:1] ^ strap) & CMASK) == 3'b000);

  assign ptr_pg   = {ptr[AW-1:PW], ptr[PW-1:0] + PW'(1)};
  assign rd_addr  = ptr;
  assign sda_pull = ack | ((st == S_RD) && !cnt[3] && !tx[~cnt[2:0]]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sr <= '0; tx <= '0; dbits <= '0;
      rwb <= 1'b0; ack <= 1'b0; mack <= 1'b0; pend <= 1'b0;
      ptr <= '0; pg_we <= 1'b0; pg_addr <= '0; pg_data <= '0; wr_go <= 1'b0;
    end else begin
      pg_we <= 1'b0;
      wr_go <= 1'b0;
      if (bus_stop) begin
        st <= S_IDLE; cnt <= '0; ack <= 1'b0;
        wr_go <= pend;
        pend <= 1'b0;
      end else if (bus_start) begin
        st <= wr_busy ? S_WAIT : S_DEV;
        cnt <= '0; ack <= 1'b0; pend <= 1'b0;
      end else begin
        case (st)
          S_DEV, S_WAD, S_WDT: begin
            if (scl_rise && !cnt[3]) sr <= {sr[6:0], sda_in};
            if (scl_fall) begin
              if (cnt < 4'd7) begin
                cnt <= cnt + 4'd1;
              end else if (cnt == 4'd7) begin
                cnt <= 4'd8;
                if (st == S_DEV) begin
                  ack   <= dev_hit;
                  rwb   <= sr[0];
                  dbits <= sr[3:1];
                end else if (st == S_WAD) begin
                  ack <= 1'b1;
                  ptr <= AW'({dbits, sr});
                end else if (!wr_protect) begin
                  ack     <= 1'b1;
                  pg_we   <= 1'b1;
                  pg_addr <= ptr;
                  pg_data <= sr;
                  ptr     <= ptr_pg;
                  pend    <= 1'b1;
                end else begin
                  ack <= 1'b0;
                end
              end else begin
                ack <= 1'b0;
                cnt <= '0;
                if (!ack) st <= S_WAIT;
                else if (st == S_DEV) begin
                  if (rwb) begin
                    st  <= S_RD;
                    tx  <= rd_data;
                    ptr <= ptr + 1'b1;
                  end else begin
                    st <= S_WAD;
                  end
                end else begin
                  st <= S_WDT;
                end
              end
            end
          end
          S_RD: begin
            if (scl_rise && cnt[3]) mack <= !sda_in;
            if (scl_fall) begin
              if (!cnt[3]) begin
                cnt <= cnt + 4'd1;
              end else if (mack) begin
                tx  <= rd_data;
                ptr <= ptr + 1'b1;
                cnt <= '0;
              end else begin
                st <= S_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_eeprom_engine_props.sv
module i2c_eeprom_engine_props #(
  parameter int AW = 11,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_start,
  input logic          bus_stop,
  input logic          scl_fall,
  input logic          sda_pull,
  input logic          wr_protect,
  input logic          wr_busy,
  input logic [AW-1:0] rd_addr,
  input logic          pg_we,
  input logic [AW-1:0] pg_addr,
  input logic          wr_go
);

  assert_sda_moves_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_fall && !bus_start && !bus_stop) |=> $stable(sda_pull));

  assert_go_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> $past(bus_stop));

  assert_page_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pg_we |-> (rd_addr[AW-1:PW] == pg_addr[AW-1:PW]));

  assert_busy_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> !sda_pull);

  assert_protect_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pg_we |-> !$past(wr_protect));

  assert_stop_releases_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stop || bus_start) |=> (!sda_pull && !pg_we));

endmodule

bind i2c_eeprom_engine i2c_eeprom_engine_props #(.AW(AW), .PW(PW)) u_props (
  .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
  .scl_fall(scl_fall), .sda_pull(sda_pull), .wr_protect(wr_protect),
  .wr_busy(wr_busy), .rd_addr(rd_addr), .pg_we(pg_we), .pg_addr(pg_addr),
  .wr_go(wr_go)
);

// File: tb/test_i2c_eeprom_engine.sv
module test_i2c_eeprom_engine;
  localparam int BYTES = 512;
  localparam int AW    = 9;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic bus_start = 1'b0, bus_stop = 1'b0, scl_rise = 1'b0, scl_fall = 1'b0;
  logic m_sda = 1'b1;
  logic sda_in, sda_pull;
  logic [2:0] strap = 3'b100;
  logic wr_protect = 1'b0;
  logic wr_busy;
  logic [AW-1:0] rd_addr, pg_addr;
  logic [7:0] rd_data, pg_data;
  logic pg_we, wr_go;

  int checks = 0, fails = 0, go_count = 0, busy_cnt;
  logic [7:0] mem [BYTES];
  logic [7:0] stage [BYTES];
  logic       stv [BYTES];
  logic [7:0] model [BYTES];
  logic [AW+7:0] expq [$];

  assign sda_in  = m_sda & ~sda_pull;
  assign rd_data = mem[rd_addr];
  assign wr_busy = busy_cnt > 0;

  i2c_eeprom_engine #(.BYTES(BYTES), .PAGE(16)) i_i2c_eeprom_engine (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in), .sda_pull(sda_pull),
    .strap(strap), .wr_protect(wr_protect), .wr_busy(wr_busy),
    .rd_addr(rd_addr), .rd_data(rd_data), .pg_we(pg_we), .pg_addr(pg_addr),
    .pg_data(pg_data), .wr_go(wr_go));

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) begin mem[i] <= 8'(i * 37 + 5); stv[i] <= 1'b0; end
      busy_cnt <= 0;
    end else begin
      if (wr_go) begin
        for (int i = 0; i < BYTES; i++) if (stv[i]) begin mem[i] <= stage[i]; stv[i] <= 1'b0; end
        busy_cnt <= 40;
      end else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
      if (pg_we) begin stage[pg_addr] <= pg_data; stv[pg_addr] <= 1'b1; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (pg_we) begin
      if (expq.size() == 0) check(0, "R4 unexpected page write", int'({pg_addr, pg_data}), 0);
      else begin
        logic [AW+7:0] e;
        e = expq.pop_front();
        check({pg_addr, pg_data} == e, "R4/R5 page write", int'({pg_addr, pg_data}), int'(e));
      end
    end
    if (wr_go) go_count++;
  end

  task automatic do_start();
    @(negedge clk) bus_start = 1'b1;
    @(negedge clk) bus_start = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk) begin bus_stop = 1'b1; m_sda = 1'b1; end
    @(negedge clk) bus_stop = 1'b0;
  endtask

  task automatic bit_cycle(input logic b, output logic pulled);
    @(negedge clk) begin m_sda = b; scl_rise = 1'b1; end
    @(negedge clk) scl_rise = 1'b0;
    @(negedge clk) begin pulled = sda_pull; scl_fall = 1'b1; end
    @(negedge clk) scl_fall = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic p;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(b[i], p);
      if (p) check(0, "R1 line held during master bit", 1, 0);
    end
    bit_cycle(1'b1, p);
    acked = p;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    logic p;
    for (int i = 7; i >= 0; i--) begin bit_cycle(1'b1, p); d[i] = !p; end
    bit_cycle(!mack, p);
  endtask

  task automatic set_ptr(input logic [AW-1:0] a);
    logic ak;
    do_start();
    send_byte({4'hA, 2'b10, a[8], 1'b0}, ak);
    check(ak, "R2 write header ack", ak, 1);
    send_byte(a[7:0], ak);
    check(ak, "R4 word address ack", ak, 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic ak, p;
    logic [7:0] d;
    for (int i = 0; i < BYTES; i++) model[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    check(!sda_pull && !pg_we && !wr_go && rd_addr == 0, "R13 reset state",
          int'({sda_pull, pg_we, wr_go}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4 byte write at 0x1A5
    set_ptr(9'h1A5);
    expq.push_back({9'h1A5, 8'h3C});
    send_byte(8'h3C, ak);
    check(ak, "R4 data ack", ak, 1);
    do_stop();
    repeat (2) @(negedge clk);
    check(go_count == 1, "R4 wr_go at stop", go_count, 1);
    model[9'h1A5] = 8'h3C;

    // R6 polling while busy
    do_start();
    send_byte(8'hA8, ak);
    check(!ak, "R6 no ack while busy", ak, 0);
    send_byte(8'h00, ak);
    check(!ak, "R6 still silent", ak, 0);
    do_stop();
    repeat (60) @(negedge clk);
    do_start();
    send_byte(8'hA8, ak);
    check(ak, "R6 ack after busy", ak, 1);
    do_stop();
    check(go_count == 1, "R4 no wr_go without data", go_count, 1);

    // R7 random read
    set_ptr(9'h1A5);
    do_start();
    send_byte(8'hAB, ak);
    check(ak, "R2 read header ack", ak, 1);
    recv_byte(0, d);
    check(d == model[9'h1A5], "R7 random read", d, model[9'h1A5]);
    do_stop();

    // R8 current address read, block bits of header ignored
    do_start();
    send_byte(8'hA9, ak);
    recv_byte(0, d);
    check(d == model[9'h1A6], "R8 current read", d, model[9'h1A6]);
    do_stop();

    // R2 strap[0] ignored at 512 bytes
    strap = 3'b101;
    do_start();
    send_byte(8'hA9, ak);
    check(ak, "R2 strap0 ignored", ak, 1);
    recv_byte(0, d);
    check(d == model[9'h1A7], "R8 pointer advanced", d, model[9'h1A7]);
    do_stop();
    strap = 3'b100;

    // R9 sequential wrap, R10 nack
    set_ptr(9'h1FE);
    do_start();
    send_byte(8'hAB, ak);
    recv_byte(1, d);
    check(d == model[9'h1FE], "R9 seq byte 0", d, model[9'h1FE]);
    recv_byte(1, d);
    check(d == model[9'h1FF], "R9 seq byte 1", d, model[9'h1FF]);
    recv_byte(0, d);
    check(d == model[0], "R9 wrap to 0", d, model[0]);
    for (int i = 0; i < 9; i++) begin
      bit_cycle(1'b1, p);
      if (p) check(0, "R10 released after nack", 1, 0);
    end
    check(!sda_pull, "R10 released after nack", sda_pull, 0);
    do_stop();

    // R3 address mismatch
    do_start();
    send_byte(8'hA0, ak);
    check(!ak, "R3 strap mismatch", ak, 0);
    send_byte(8'h00, ak);
    check(!ak, "R3 silent after mismatch", ak, 0);
    do_stop();
    do_start();
    send_byte(8'hB8, ak);
    check(!ak, "R2 wrong identifier", ak, 0);
    do_stop();

    // R5 page write with rollover
    set_ptr(9'h0F0);
    for (int k = 0; k < 18; k++) begin
      expq.push_back({9'h0F0 + 9'(k % 16), 8'(8'h50 + k)});
      send_byte(8'(8'h50 + k), ak);
      check(ak, "R5 page data ack", ak, 1);
    end
    do_stop();
    for (int k = 0; k < 18; k++) model[9'h0F0 + k % 16] = 8'(8'h50 + k);
    repeat (60) @(negedge clk);
    check(go_count == 2, "R5 wr_go", go_count, 2);
    set_ptr(9'h0F0);
    do_start();
    send_byte(8'hA9, ak);
    for (int k = 0; k < 16; k++) begin
      recv_byte(k != 15, d);
      check(d == model[9'h0F0 + k], "R5 page readback", d, model[9'h0F0 + k]);
    end
    do_stop();

    // R11 write protect
    @(negedge clk) wr_protect = 1'b1;
    set_ptr(9'h010);
    send_byte(8'h77, ak);
    check(!ak, "R11 data not acked", ak, 0);
    do_stop();
    repeat (2) @(negedge clk);
    check(go_count == 2, "R11 no wr_go", go_count, 2);
    wr_protect = 1'b0;
    set_ptr(9'h010);
    do_start();
    send_byte(8'hA9, ak);
    recv_byte(0, d);
    check(d == model[9'h010], "R11 memory unchanged", d, model[9'h010]);
    do_stop();

    // R12 start mid byte aborts
    do_start();
    for (int i = 0; i < 4; i++) bit_cycle(1'b1, p);
    do_start();
    send_byte(8'hA9, ak);
    check(ak, "R12 restart after abort", ak, 1);
    recv_byte(0, d);
    check(d == model[9'h011], "R12 read after abort", d, model[9'h011]);
    do_stop();

    // R12 repeated start cancels pending write
    set_ptr(9'h020);
    expq.push_back({9'h020, 8'h99});
    send_byte(8'h99, ak);
    check(ak, "R4 data ack before abort", ak, 1);
    do_start();
    do_stop();
    repeat (3) @(negedge clk);
    check(go_count == 2, "R12 pending write cancelled", go_count, 2);
    check(expq.size() == 0, "R4 all page writes seen", expq.size(), 0);

    finish_run();
  end
endmodule